// File: doc/BRIEF.md
# Matrix Max-Pool and ReLU Engine

This engine runs one element-wise matrix command at a time against an on-chip scratchpad. A command gives a 3-bit function code, a source start address, the side length N of a square source matrix and a destination start address. For max pooling it also gives a packed 32-bit operand that holds the window side K and the stride S. The engine reads source elements through a buffer read port with one cycle of latency. It either takes the largest value in each sliding window or clamps negative values to zero. It writes each result through a buffer write port.

The source matrix is stored row-major: element (i, j) is at `src + i*N + j`. Pooling scans windows in row-major output order and reads the elements of each window in row-major order, one read per cycle. ReLU uses the same path with a 1x1 window and stride 1. A running maximum is kept per window and a result is written when the window's last element arrives. Illegal commands finish at once, flag an error and touch neither port.

Top module: `mpool_relu_engine`

## Requirements
- R1: Function code 3'b100 selects max pooling and 3'b101 selects ReLU. Any other code is an illegal command.
- R2: For pooling, bits [31:16] of the packed operand give the window side K and bits [15:0] give the stride S.
- R3: Pooling writes M*M results, with M = floor((N-K)/S)+1. Result (r, c) is the signed maximum of the KxK window whose top-left element is (r*S, c*S). It is written to `dst + r*M + c`, and results are written in row-major order.
- R4: ReLU writes N*N results. Result i goes to `dst + i` and is 0 when source element i is negative; otherwise it equals the source element. Elements are 16-bit two's complement.
- R5: ReLU ignores the packed operand, including values that would be illegal for pooling.
- R6: A start is accepted only while the engine is idle. A start pulse while busy changes no read, write or completion timing.
- R7: busy rises in the cycle after an accepted legal start. It stays high up to and including the cycle of the last write. done is high for exactly one cycle, the cycle after the last write, and busy is low then.
- R8: Reads are issued one per cycle, starting in the cycle after the start is accepted, in window-major then row-major order. A result is written two cycles after the read of the last element of its window.
- R9: A pooling command with S=0, K=0 or K>N, a command with N=0, or an unknown function code makes done and err high together for one cycle, in the cycle after the start. It issues no read and no write, and busy stays low. err is low at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, sampled when idle |
| func | input | 3 | Function code |
| src_addr | input | ADDR_W | Source matrix start address |
| mat_size | input | DIM_W | Matrix side N |
| dst_addr | input | ADDR_W | Destination start address |
| win_stride | input | 32 | Packed window side (high half) and stride (low half) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal command, high with done |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | ADDR_W | Buffer read address |
| rd_data | input | DATA_W | Buffer read data, one cycle after rd_en |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W | Buffer write address |
| wr_data | output | DATA_W | Buffer write data |

## Verification
The bench uses the default parameters: 16-bit data, 10-bit addresses and an 8-bit size field, backed by a 1024-word buffer model. With these values it can reach overlapping windows (S<K), gapped windows (S>K), a single window covering the whole matrix with a stride wider than N, all-negative windows that include the most negative code, and ReLU on the extreme codes. It also runs every illegal form and a start pulse issued in the middle of a command.

// File: rtl/mpre_pkg.sv
package mpre_pkg;
  localparam logic [2:0] FN_POOL = 3'b100;
  localparam logic [2:0] FN_RELU = 3'b101;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT} st_t;

  typedef struct packed {
    logic first;
    logic last;
    logic fin;
    logic relu;
  } rtag_t;
endpackage

// File: rtl/mpre_seq.sv
module mpre_seq
  import mpre_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        func,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [DIM_W-1:0]  mat_size,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [31:0]       win_stride,
  input  logic              fin_wr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output rtag_t             iss_tag,
  output logic [ADDR_W-1:0] iss_waddr,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

  st_t               state;
  logic [DIM_W-1:0]  n_q, k_q, s_q, m_q;
  logic [DIM_W-1:0]  orow, ocol, wrow, wcol;
  logic              relu_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic              done_q, err_q;

  logic [15:0]       k_in, s_in, s_div;
  logic              is_pool, is_relu, bad;
  logic [31:0]       m_pool32;
  logic [DIM_W-1:0]  s_clamp;
  logic              last_wc, last_wr, last_oc, last_or;
  logic [31:0]       row32, col32, out32;

  always_comb begin
    k_in     = win_stride[31:16];
    s_in     = win_stride[15:0];
    is_pool  = (func == FN_POOL);
    is_relu  = (func == FN_RELU);
    bad      = (!is_pool && !is_relu) || (mat_size == '0) ||
               (is_pool && ((k_in == 16'd0) || (s_in == 16'd0) ||
                            (32'(k_in) > 32'(mat_size))));
    s_div    = (s_in == 16'd0) ? 16'd1 : s_in;
    m_pool32 = (32'(mat_size) - 32'(k_in)) / 32'(s_div) + 32'd1;
    s_clamp  = (32'(s_in) > 32'(mat_size)) ? mat_size : DIM_W'(s_in);
  end

  always_comb begin
    last_wc = (wcol == k_q - ONE);
    last_wr = (wrow == k_q - ONE);
    last_oc = (ocol == m_q - ONE);
    last_or = (orow == m_q - ONE);
    row32   = (32'(orow) * 32'(s_q) + 32'(wrow)) * 32'(n_q);
    col32   = 32'(ocol) * 32'(s_q) + 32'(wcol);
    out32   = 32'(orow) * 32'(m_q) + 32'(ocol);
  end

  assign rd_en         = (state == ST_RUN);
  assign rd_addr       = src_q + ADDR_W'(row32 + col32);
  assign iss_waddr     = dst_q + ADDR_W'(out32);
  assign iss_tag.first = (wrow == '0) && (wcol == '0);
  assign iss_tag.last  = last_wc && last_wr;
  assign iss_tag.fin   = last_wc && last_wr && last_oc && last_or;
  assign iss_tag.relu  = relu_q;
  assign busy          = (state != ST_IDLE);
  assign done          = done_q;
  assign err           = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      n_q    <= '0;
      k_q    <= '0;
      s_q    <= '0;
      m_q    <= '0;
      orow   <= '0;
      ocol   <= '0;
      wrow   <= '0;
      wcol   <= '0;
      relu_q <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (bad) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else begin
              n_q    <= mat_size;
              k_q    <= is_pool ? DIM_W'(k_in) : ONE;
              s_q    <= is_pool ? s_clamp : ONE;
              m_q    <= is_pool ? DIM_W'(m_pool32) : mat_size;
              relu_q <= is_relu;
              src_q  <= src_addr;
              dst_q  <= dst_addr;
              orow   <= '0;
              ocol   <= '0;
              wrow   <= '0;
              wcol   <= '0;
              state  <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (!last_wc) begin
            wcol <= wcol + ONE;
          end else begin
            wcol <= '0;
            if (!last_wr) begin
              wrow <= wrow + ONE;
            end else begin
              wrow <= '0;
              if (!last_oc) begin
                ocol <= ocol + ONE;
              end else begin
                ocol <= '0;
                orow <= orow + ONE;
              end
            end
          end
          if (iss_tag.fin) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (fin_wr) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R6
  start_busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !fin_wr) |=> busy);
endmodule

// File: rtl/mpre_dp.sv
module mpre_dp
  import mpre_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_vld,
  input  rtag_t             iss_tag,
  input  logic [ADDR_W-1:0] iss_waddr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              fin_wr
);
  logic              t_vld;
  rtag_t             t_tag;
  logic [ADDR_W-1:0] t_waddr;
  logic [DATA_W-1:0] acc, cand;
  logic              wr_relu;

  always_comb begin
    if (t_tag.first || ($signed(rd_data) > $signed(acc))) cand = rd_data;
    else                                                  cand = acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_vld   <= 1'b0;
      t_tag   <= '0;
      t_waddr <= '0;
      acc     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      fin_wr  <= 1'b0;
      wr_relu <= 1'b0;
    end else begin
      t_vld   <= iss_vld;
      t_tag   <= iss_tag;
      t_waddr <= iss_waddr;
      wr_en   <= 1'b0;
      fin_wr  <= 1'b0;
      if (t_vld) begin
        acc <= cand;
        if (t_tag.last) begin
          wr_en   <= 1'b1;
          wr_addr <= t_waddr;
          wr_data <= (t_tag.relu && cand[DATA_W-1]) ? '0 : cand;
          fin_wr  <= t_tag.fin;
          wr_relu <= t_tag.relu;
        end
      end
    end
  end

  // R4
  relu_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_relu) |-> !wr_data[DATA_W-1]);

  // R3
  fin_has_write_chk: assert property (@(posedge clk) disable iff (rst)
    fin_wr |-> wr_en);
endmodule

// File: rtl/mpool_relu_engine.sv
module mpool_relu_engine
  import mpre_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int DIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        func,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [DIM_W-1:0]  mat_size,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [31:0]       win_stride,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  rtag_t             iss_tag;
  logic [ADDR_W-1:0] iss_waddr;
  logic              fin_wr;

  mpre_seq #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .func(func),
    .src_addr(src_addr), .mat_size(mat_size), .dst_addr(dst_addr),
    .win_stride(win_stride), .fin_wr(fin_wr),
    .rd_en(rd_en), .rd_addr(rd_addr), .iss_tag(iss_tag),
    .iss_waddr(iss_waddr), .busy(busy), .done(done), .err(err)
  );

  mpre_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .iss_vld(rd_en), .iss_tag(iss_tag),
    .iss_waddr(iss_waddr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .fin_wr(fin_wr)
  );

  // R8
  rd_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);

  // R7
  wr_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

  // R9
  err_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!rd_en && !wr_en));
endmodule

// File: tb/sim_mpool_relu_engine.sv
module sim_mpool_relu_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 10;
  localparam int DIM_W  = 8;
  localparam logic [2:0] F_POOL = 3'b100;
  localparam logic [2:0] F_RELU = 3'b101;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [2:0]        func = '0;
  logic [ADDR_W-1:0] src_addr = '0;
  logic [DIM_W-1:0]  mat_size = '0;
  logic [ADDR_W-1:0] dst_addr = '0;
  logic [31:0]       win_stride = '0;
  logic              busy, done, err, rd_en, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data = '0;
  logic [DATA_W-1:0] wr_data;

  logic [DATA_W-1:0] mem [0:(1<<ADDR_W)-1];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;

  int rd_cyc[$], rd_adr[$];
  int wr_cyc[$], wr_adr[$], wr_dat[$];
  int exp_a = -10, exp_done = -10;
  bit exp_bad = 1'b0;
  string req_w = "R3";

  mpool_relu_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIM_W(DIM_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .func(func), .src_addr(src_addr),
    .mat_size(mat_size), .dst_addr(dst_addr), .win_stride(win_stride),
    .busy(busy), .done(done), .err(err), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // cycle-by-cycle comparison against the expectation queues
  always @(negedge clk) begin
    if (mon_on) begin
      if (rd_en) begin
        checks++;
        if (rd_cyc.size() == 0 || rd_cyc[0] != cyc || rd_adr[0] != int'(rd_addr)) begin
          errors++;
          $display("FAIL R8 cycle %0d read addr actual=%0d expected=%0d", cyc,
                   rd_addr, (rd_adr.size() > 0) ? rd_adr[0] : -1);
        end
        if (rd_cyc.size() > 0) begin
          void'(rd_cyc.pop_front());
          void'(rd_adr.pop_front());
        end
      end else if (rd_cyc.size() > 0 && rd_cyc[0] == cyc) begin
        checks++;
        errors++;
        $display("FAIL R8 cycle %0d read actual=none expected=%0d", cyc, rd_adr[0]);
        void'(rd_cyc.pop_front());
        void'(rd_adr.pop_front());
      end

      if (wr_en) begin
        checks++;
        if (wr_cyc.size() == 0 || wr_cyc[0] != cyc || wr_adr[0] != int'(wr_addr) ||
            wr_dat[0] != int'($signed(wr_data))) begin
          errors++;
          $display("FAIL %s cycle %0d write actual=%0d:%0d expected=%0d:%0d", req_w, cyc,
                   wr_addr, $signed(wr_data), (wr_adr.size() > 0) ? wr_adr[0] : -1,
                   (wr_dat.size() > 0) ? wr_dat[0] : 0);
        end
        if (wr_cyc.size() > 0) begin
          void'(wr_cyc.pop_front());
          void'(wr_adr.pop_front());
          void'(wr_dat.pop_front());
        end
      end else if (wr_cyc.size() > 0 && wr_cyc[0] == cyc) begin
        checks++;
        errors++;
        $display("FAIL %s cycle %0d write actual=none expected=%0d", req_w, cyc, wr_adr[0]);
        void'(wr_cyc.pop_front());
        void'(wr_adr.pop_front());
        void'(wr_dat.pop_front());
      end

      checks++;
      if (busy != (cyc >= exp_a && cyc < exp_done)) begin
        errors++;
        $display("FAIL R7 cycle %0d busy actual=%0b expected=%0b", cyc, busy,
                 (cyc >= exp_a && cyc < exp_done));
      end
      checks++;
      if (done != (cyc == exp_done)) begin
        errors++;
        $display("FAIL R7 cycle %0d done actual=%0b expected=%0b", cyc, done, (cyc == exp_done));
      end
      checks++;
      if (err != (cyc == exp_done && exp_bad)) begin
        errors++;
        $display("FAIL R9 cycle %0d err actual=%0b expected=%0b", cyc, err,
                 (cyc == exp_done && exp_bad));
      end
    end
  end

  task automatic fill(input int base, input int cnt, input int seed, input bit neg);
    logic [31:0] x;
    x = 32'(seed);
    for (int i = 0; i < cnt; i++) begin
      x = x * 32'd1103515245 + 32'd12345;
      mem[base + i] = neg ? (16'h8000 | x[23:8]) : x[30:15];
    end
  endtask

  task automatic run_cmd(input logic [2:0] fn, input int src, input int n, input int dst,
                         input int k, input int s, input bit bad, input string rq,
                         input int poke);
    int a, kk, ss, mm, idx, mx, v, ad;
    bit relu;
    @(negedge clk);
    a = cyc + 1;
    req_w = rq;
    exp_a = a;
    exp_bad = bad;
    if (bad) begin
      exp_done = a;
    end else begin
      relu = (fn == F_RELU);
      kk = relu ? 1 : k;
      ss = relu ? 1 : s;
      mm = relu ? n : (n - kk) / ss + 1;
      idx = 0;
      for (int r = 0; r < mm; r++) begin
        for (int c = 0; c < mm; c++) begin
          mx = 0;
          for (int wr = 0; wr < kk; wr++) begin
            for (int wc = 0; wc < kk; wc++) begin
              ad = src + (r * ss + wr) * n + c * ss + wc;
              v = int'($signed(mem[ad]));
              rd_cyc.push_back(a + idx);
              rd_adr.push_back(ad);
              if ((wr == 0 && wc == 0) || v > mx) mx = v;
              idx++;
            end
          end
          if (relu && mx < 0) mx = 0;
          wr_cyc.push_back(a + idx + 1);
          wr_adr.push_back(dst + r * mm + c);
          wr_dat.push_back(mx);
        end
      end
      exp_done = a + idx + 2;
    end
    start = 1'b1;
    func = fn;
    src_addr = ADDR_W'(src);
    mat_size = DIM_W'(n);
    dst_addr = ADDR_W'(dst);
    win_stride = {16'(k), 16'(s)};
    @(negedge clk);
    start = 1'b0;
    if (poke > 0) begin
      repeat (poke - 1) @(negedge clk);
      start = 1'b1;
      func = F_POOL;
      src_addr = ADDR_W'(700);
      mat_size = DIM_W'(2);
      dst_addr = ADDR_W'(900);
      win_stride = {16'd1, 16'd1};
      @(negedge clk);
      start = 1'b0;
    end
    while (cyc <= exp_done) @(negedge clk);
    checks++;
    if (rd_cyc.size() != 0 || wr_cyc.size() != 0) begin
      errors++;
      $display("FAIL %s leftover actual=%0d reads %0d writes expected=0", rq,
               rd_cyc.size(), wr_cyc.size());
      rd_cyc.delete(); rd_adr.delete();
      wr_cyc.delete(); wr_adr.delete(); wr_dat.delete();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R7 reset state
    checks++;
    if (busy || done || err || rd_en || wr_en) begin
      errors++;
      $display("FAIL R7 reset outputs actual=%0b%0b%0b%0b%0b expected=00000",
               busy, done, err, rd_en, wr_en);
    end
    rst = 1'b0;
    mon_on = 1'b1;

    // R4 R5: ReLU on mixed values, packed operand zero (illegal for pooling)
    fill(0, 16, 7, 1'b0);
    for (int i = 0; i < 16; i += 3) mem[i] = mem[i] | 16'h8000;
    run_cmd(F_RELU, 0, 4, 512, 0, 0, 1'b0, "R4", 0);
    // R5: ReLU with window larger than N and huge stride
    run_cmd(F_RELU, 0, 3, 540, 200, 9, 1'b0, "R5", 0);
    // R3 R2 R1: 2x2 window, stride 2
    fill(20, 16, 11, 1'b0);
    run_cmd(F_POOL, 20, 4, 560, 2, 2, 1'b0, "R3", 0);
    // R3: overlapping 3x3 windows, stride 1
    fill(40, 25, 23, 1'b0);
    run_cmd(F_POOL, 40, 5, 580, 3, 1, 1'b0, "R3", 0);
    // R3: gapped windows, stride 3 with K=2
    fill(70, 36, 5, 1'b0);
    run_cmd(F_POOL, 70, 6, 600, 2, 3, 1'b0, "R3", 0);
    // R2 R3: window equals N, stride wider than N
    run_cmd(F_POOL, 70, 6, 620, 6, 40, 1'b0, "R2", 0);
    // R3: all-negative data including most negative code
    fill(110, 16, 99, 1'b1);
    mem[115] = 16'h8000;
    run_cmd(F_POOL, 110, 4, 640, 2, 1, 1'b0, "R3", 0);
    // R4: extreme codes
    mem[300] = 16'h8000; mem[301] = 16'h7fff; mem[302] = 16'h0000; mem[303] = 16'hffff;
    run_cmd(F_RELU, 300, 2, 660, 0, 0, 1'b0, "R4", 0);
    // R9: illegal commands
    run_cmd(F_POOL, 20, 4, 680, 2, 0, 1'b1, "R9", 0);
    run_cmd(F_POOL, 20, 4, 680, 5, 1, 1'b1, "R9", 0);
    run_cmd(F_POOL, 20, 4, 680, 0, 1, 1'b1, "R9", 0);
    run_cmd(3'b011, 20, 4, 680, 2, 2, 1'b1, "R1", 0);
    run_cmd(F_RELU, 20, 0, 680, 0, 0, 1'b1, "R9", 0);
    // R6: start pulse in the middle of a ReLU run is ignored
    run_cmd(F_RELU, 0, 4, 720, 0, 0, 1'b0, "R6", 3);
    // R6: start pulse in the middle of a pooling run is ignored
    run_cmd(F_POOL, 40, 5, 760, 3, 2, 1'b0, "R6", 6);
    // R8: back-to-back single-element pooling
    run_cmd(F_POOL, 40, 1, 780, 1, 1, 1'b0, "R8", 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule